// File: doc/BRIEF.md
# Shadow-RAM Expansion Address Decoder

This block sits between an 8-bit microprocessor bus and a 32K×8 static RAM expansion. It makes the RAM chip enable, strobes and upper address bit. It also makes an active-low override that can force the internal ROM off the data bus, and a select for a four-address memory-mapped I/O port. The block first sorts each bus state into idle, memory access, refresh, I/O or interrupt acknowledge. Only ordinary memory accesses can select the RAM, the port or the override. As a result, at most one device drives the data bus in any cycle.

The RAM is split into two 16K halves. Half 0 answers at 4000h–7FFFh. Half 1 answers data accesses at C000h–FFFFh and also backs the 8K ghost region at 0000h–1FFFh. The video circuit runs the display file with opcode fetches from the upper mirror. Such a fetch is folded onto the lower copy, so it reads the same cell as the address with bit 15 cleared. A shadow switch chooses how the ghost region behaves:
- **Switch off:** ROM serves reads and RAM takes writes, so a ROM image can be copied in.
- **Switch on:** RAM answers both reads and writes, and the ROM is held off.

The switch is synchronised to the clock and only takes effect between memory requests. RAM address lines 13..0 connect straight from the bus and do not pass through the block.

Top module: `shadow_ram_decoder`

## Requirements
- R1: A memory-read opcode fetch (/MREQ, /RD, /M1 low, /IORQ and /RFSH high) at C000h–FFFFh selects RAM (ram_ce_n low) with ram_bank 0, the same cell as the address minus 8000h.
- R2: Data accesses (/M1 high) at 4000h–7FFFh select RAM with ram_bank 0. Data accesses at C000h–FFFBh select RAM with ram_bank 1.
- R3: With EXEC_NEEDS_A14 = 0, an opcode fetch at 8000h–BFFFh is folded to 0000h–3FFFh. With EXEC_NEEDS_A14 = 1 it is not folded, and it selects neither RAM nor the override.
- R4: With shadow mode off, writes to 0000h–1FFFh select RAM with ram_bank 1. Reads there leave ram_ce_n high and rom_off_n high.
- R5: With shadow mode on, reads and writes to 0000h–1FFFh select RAM with ram_bank 1 and drive rom_off_n low.
- R6: Data accesses at FFFCh–FFFFh raise port_sel and keep ram_ce_n high. An opcode fetch there is folded to RAM instead.
- R7: In I/O cycles (/IORQ low) and interrupt acknowledge (/IORQ and /M1 low), ram_ce_n and rom_off_n stay high and port_sel stays low, whatever the address.
- R8: In refresh cycles (/MREQ and /RFSH low), ram_ce_n and rom_off_n stay high, so character lookups are served by the ROM.
- R9: rom_off_n is low only while /MREQ is low.
- R10: ram_oe_n equals /RD and ram_we_n equals /WR at all times.
- R11: Reset leaves shadow mode off. A change of shadow_sw takes effect only after it passes two synchroniser flops and /MREQ is high at a clock edge. While /MREQ stays low, the mode does not change.
- R12: Data accesses at 2000h–3FFFh and 8000h–BFFFh select neither RAM, port nor the override.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the shadow-switch synchroniser and mode register |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Processor address bus |
| mreq_n | input | 1 | Memory request, active low |
| iorq_n | input | 1 | I/O request, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| m1_n | input | 1 | Opcode fetch / acknowledge marker, active low |
| rfsh_n | input | 1 | Refresh marker, active low |
| shadow_sw | input | 1 | Asynchronous shadow-enable switch, high = RAM replaces ROM |
| ram_ce_n | output | 1 | RAM chip enable, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| ram_bank | output | 1 | RAM address bit 14 (half select) |
| rom_off_n | output | 1 | ROM override, low forces the internal ROM off |
| port_sel | output | 1 | I/O port window select, active high |

## Verification
The bench builds two copies side by side and drives both with the same bus stimulus. One copy uses EXEC_NEEDS_A14 = 0 and the other EXEC_NEEDS_A14 = 1. Both keep SYNC_STAGES = 2, PORT_AW = 2 and GHOST_AW = 13. Together they show, under shadow mode, that a fetch at 8000h–9FFFh diverges: the first copy folds it into the ghost RAM and the second leaves it to the ROM. Fetches at C000h–FFFFh fold identically in both. The two-flop setting also makes the switch-to-mode latency short enough to time exactly while /MREQ is held low across a flip.

// File: rtl/shadow_dec_pkg.sv
package shadow_dec_pkg;

  // Kind of bus state seen on the control lines this clock.
  typedef enum logic [2:0] {
    CYC_IDLE    = 3'd0,
    CYC_MEM     = 3'd1,
    CYC_REFRESH = 3'd2,
    CYC_IO      = 3'd3,
    CYC_INTACK  = 3'd4
  } bus_cyc_e;

  // Result of the memory map lookup.
  typedef struct packed {
    logic ram_hit;
    logic bank;
    logic rom_kill;
    logic port_hit;
  } map_res_t;

endpackage

// File: rtl/bus_cycle_classify.sv
module bus_cycle_classify
  import shadow_dec_pkg::*;
(
  input  logic     mreq_n,
  input  logic     iorq_n,
  input  logic     m1_n,
  input  logic     rfsh_n,
  output bus_cyc_e cyc
);

  // I/O request wins over everything: an illegal overlap with /MREQ
  // is treated as I/O so that no memory device is enabled.
  always_comb begin
    if (!iorq_n && !m1_n)       cyc = CYC_INTACK;
    else if (!iorq_n)           cyc = CYC_IO;
    else if (!mreq_n && !rfsh_n) cyc = CYC_REFRESH;
    else if (!mreq_n)           cyc = CYC_MEM;
    else                        cyc = CYC_IDLE;
  end

endmodule

// File: rtl/shadow_mode_sync.sv
module shadow_mode_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_async,
  input  logic bus_idle,
  output logic shadow_on
);

  logic [SYNC_STAGES-1:0] chain_q, chain_nxt;
  logic                   mode_q, mode_nxt;
  logic                   mode_en;

  // Synchroniser next state: shift the raw switch in at the bottom.
  always_comb begin
    chain_nxt = {chain_q[SYNC_STAGES-2:0], sw_async};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_nxt;
  end

  // Mode register: clock enable only between memory requests.
  always_comb begin
    mode_en  = bus_idle;
    mode_nxt = chain_q[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= 1'b0;
    else if (mode_en) mode_q <= mode_nxt;
  end

  assign shadow_on = mode_q;

endmodule

// File: rtl/sram_map_decode.sv
module sram_map_decode
  import shadow_dec_pkg::*;
#(
  parameter int ADDR_W         = 16,
  parameter int PORT_AW        = 2,
  parameter int GHOST_AW       = 13,
  parameter bit EXEC_NEEDS_A14 = 1'b0
) (
  input  bus_cyc_e          cyc,
  input  logic [ADDR_W-1:0] addr,
  input  logic              m1_n,
  input  logic              wr_n,
  input  logic              shadow_on,
  output map_res_t          res
);

  localparam int TOP = ADDR_W - 1;
  localparam int SUB = ADDR_W - 2;

  logic              mem;
  logic              fold_qual;
  logic              fold;
  logic [ADDR_W-1:0] eff;
  logic              in_port;
  logic              in_ghost;

  // Which fetches count as display execution.
  generate
    if (EXEC_NEEDS_A14) begin : g_qual_a14
      assign fold_qual = addr[SUB];
    end else begin : g_any_upper
      assign fold_qual = 1'b1;
    end
  endgenerate

  always_comb begin
    mem      = (cyc == CYC_MEM);
    fold     = mem && !m1_n && addr[TOP] && fold_qual;
    eff      = fold ? {1'b0, addr[TOP-1:0]} : addr;
    in_port  = mem && m1_n && (&addr[TOP:PORT_AW]);
    in_ghost = (eff[TOP:GHOST_AW] == '0);

    res = '0;
    if (mem) begin
      if (in_port) begin
        res.port_hit = 1'b1;
      end else if (eff[TOP:SUB] == 2'b01) begin
        res.ram_hit = 1'b1;
        res.bank    = 1'b0;
      end else if (eff[TOP:SUB] == 2'b11) begin
        res.ram_hit = 1'b1;
        res.bank    = 1'b1;
      end else if (in_ghost) begin
        if (shadow_on) begin
          res.ram_hit  = 1'b1;
          res.bank     = 1'b1;
          res.rom_kill = 1'b1;
        end else if (!wr_n) begin
          res.ram_hit = 1'b1;
          res.bank    = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/shadow_ram_decoder.sv
module shadow_ram_decoder
  import shadow_dec_pkg::*;
#(
  parameter int ADDR_W         = 16,
  parameter int PORT_AW        = 2,
  parameter int GHOST_AW       = 13,
  parameter int SYNC_STAGES    = 2,
  parameter bit EXEC_NEEDS_A14 = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              mreq_n,
  input  logic              iorq_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              m1_n,
  input  logic              rfsh_n,
  input  logic              shadow_sw,
  output logic              ram_ce_n,
  output logic              ram_oe_n,
  output logic              ram_we_n,
  output logic              ram_bank,
  output logic              rom_off_n,
  output logic              port_sel
);

  bus_cyc_e cyc;
  logic     shadow_on;
  map_res_t res;

  bus_cycle_classify u_cls (
    .mreq_n (mreq_n),
    .iorq_n (iorq_n),
    .m1_n   (m1_n),
    .rfsh_n (rfsh_n),
    .cyc    (cyc)
  );

  shadow_mode_sync #(
    .SYNC_STAGES (SYNC_STAGES)
  ) u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_async  (shadow_sw),
    .bus_idle  (mreq_n),
    .shadow_on (shadow_on)
  );

  sram_map_decode #(
    .ADDR_W         (ADDR_W),
    .PORT_AW        (PORT_AW),
    .GHOST_AW       (GHOST_AW),
    .EXEC_NEEDS_A14 (EXEC_NEEDS_A14)
  ) u_map (
    .cyc       (cyc),
    .addr      (addr),
    .m1_n      (m1_n),
    .wr_n      (wr_n),
    .shadow_on (shadow_on),
    .res       (res)
  );

  // The select lives on the chip enable; strobes pass straight through.
  assign ram_ce_n  = !res.ram_hit;
  assign ram_bank  = res.bank;
  assign rom_off_n = !res.rom_kill;
  assign port_sel  = res.port_hit;
  assign ram_oe_n  = rd_n;
  assign ram_we_n  = wr_n;

endmodule

// File: rtl/shadow_dec_chk.sv
module shadow_dec_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              mreq_n,
  input logic              iorq_n,
  input logic              rd_n,
  input logic              wr_n,
  input logic              m1_n,
  input logic              rfsh_n,
  input logic              ram_ce_n,
  input logic              ram_bank,
  input logic              rom_off_n,
  input logic              port_sel
);

  p_io_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !iorq_n |-> (ram_ce_n && rom_off_n && !port_sel));

  p_refresh_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mreq_n && !rfsh_n) |-> (ram_ce_n && rom_off_n));

  p_override_in_mreq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_off_n |-> !mreq_n);

  p_port_excludes_ram_r6: assert property (@(posedge clk) disable iff (!rst_n)
    port_sel |-> ram_ce_n);

  p_fetch_folds_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!mreq_n && iorq_n && rfsh_n && !rd_n && !m1_n && addr[ADDR_W-1] && addr[ADDR_W-2])
      |-> (!ram_ce_n && !ram_bank));

  p_mode_held_in_mreq_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!mreq_n && $stable(mreq_n) && $stable(addr) &&
     $stable({iorq_n, rd_n, wr_n, m1_n, rfsh_n}))
      |-> ($stable(ram_ce_n) && $stable(rom_off_n)));

endmodule

bind shadow_ram_decoder shadow_dec_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .addr      (addr),
  .mreq_n    (mreq_n),
  .iorq_n    (iorq_n),
  .rd_n      (rd_n),
  .wr_n      (wr_n),
  .m1_n      (m1_n),
  .rfsh_n    (rfsh_n),
  .ram_ce_n  (ram_ce_n),
  .ram_bank  (ram_bank),
  .rom_off_n (rom_off_n),
  .port_sel  (port_sel)
);

// File: tb/test_shadow_ram_decoder.sv
module test_shadow_ram_decoder;

  localparam int CLK_P = 10;
  localparam int WDOG  = 20000;

  typedef struct {
    bit ce_n;
    bit bank;
    bit bank_care;
    bit rom_off_n;
    bit port;
  } exp_t;

  typedef struct {
    exp_t e_a;
    exp_t e_q;
    bit   rd_n;
    bit   wr_n;
    bit   rom_int;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] addr;
  logic        mreq_n, iorq_n, rd_n, wr_n, m1_n, rfsh_n, shadow_sw;

  logic a_ce_n, a_oe_n, a_we_n, a_bank, a_rom_off_n, a_port;
  logic q_ce_n, q_oe_n, q_we_n, q_bank, q_rom_off_n, q_port;

  int    n_cmp  = 0;
  int    n_bad  = 0;
  bit    exp_shadow = 1'b0;
  bit    done = 1'b0;
  item_t exp_q[$];
  string tag_q[$];

  always #(CLK_P/2) clk = ~clk;

  shadow_ram_decoder i_shadow_ram_decoder (
    .clk(clk), .rst_n(rst_n), .addr(addr), .mreq_n(mreq_n), .iorq_n(iorq_n),
    .rd_n(rd_n), .wr_n(wr_n), .m1_n(m1_n), .rfsh_n(rfsh_n), .shadow_sw(shadow_sw),
    .ram_ce_n(a_ce_n), .ram_oe_n(a_oe_n), .ram_we_n(a_we_n), .ram_bank(a_bank),
    .rom_off_n(a_rom_off_n), .port_sel(a_port)
  );

  shadow_ram_decoder #(.EXEC_NEEDS_A14(1'b1)) i_shadow_ram_decoder_q (
    .clk(clk), .rst_n(rst_n), .addr(addr), .mreq_n(mreq_n), .iorq_n(iorq_n),
    .rd_n(rd_n), .wr_n(wr_n), .m1_n(m1_n), .rfsh_n(rfsh_n), .shadow_sw(shadow_sw),
    .ram_ce_n(q_ce_n), .ram_oe_n(q_oe_n), .ram_we_n(q_we_n), .ram_bank(q_bank),
    .rom_off_n(q_rom_off_n), .port_sel(q_port)
  );

  // Expected map, written from the requirements with numeric ranges.
  function automatic exp_t ref_map(bit a14q, bit shadow, logic [15:0] a,
                                   logic mq, logic io, logic wr, logic m1, logic rf);
    exp_t        e;
    logic [15:0] ea;
    e.ce_n = 1'b1; e.bank = 1'b0; e.bank_care = 1'b0; e.rom_off_n = 1'b1; e.port = 1'b0;
    ea = a;
    if (io == 1'b0 || mq == 1'b1 || rf == 1'b0) return e;          // R7 R8
    if (m1 == 1'b1 && a >= 16'hFFFC) begin e.port = 1'b1; return e; end  // R6
    if (m1 == 1'b0 && a >= 16'h8000 && (!a14q || a >= 16'hC000))
      ea = a - 16'h8000;                                             // R1 R3
    if (ea >= 16'h4000 && ea < 16'h8000) begin
      e.ce_n = 1'b0; e.bank = 1'b0; e.bank_care = 1'b1;              // R2
    end else if (ea >= 16'hC000) begin
      e.ce_n = 1'b0; e.bank = 1'b1; e.bank_care = 1'b1;              // R2
    end else if (ea < 16'h2000) begin
      if (shadow) begin
        e.ce_n = 1'b0; e.bank = 1'b1; e.bank_care = 1'b1; e.rom_off_n = 1'b0; // R5
      end else if (wr == 1'b0) begin
        e.ce_n = 1'b0; e.bank = 1'b1; e.bank_care = 1'b1;            // R4
      end
    end
    return e;                                                        // R12 otherwise
  endfunction

  task automatic bus(input logic [15:0] a, input logic mq, input logic io,
                     input logic rd, input logic wr, input logic m1,
                     input logic rf, input string tag);
    item_t it;
    @(negedge clk);
    addr = a; mreq_n = mq; iorq_n = io; rd_n = rd; wr_n = wr; m1_n = m1; rfsh_n = rf;
    it.e_a     = ref_map(1'b0, exp_shadow, a, mq, io, wr, m1, rf);
    it.e_q     = ref_map(1'b1, exp_shadow, a, mq, io, wr, m1, rf);
    it.rd_n    = rd;
    it.wr_n    = wr;
    it.rom_int = !mq && (!rd || !rf) && (a[14:13] == 2'b00);
    exp_q.push_back(it);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input string tag);
    bus(16'h0000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, tag);
  endtask

  task automatic chk(input string tag, input string what, input logic act, input logic expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, expv);
    end
  endtask

  task automatic cmp_one(input string tag, input exp_t e, input item_t it,
                         input logic ce, input logic oe, input logic we,
                         input logic bk, input logic ro, input logic pt);
    chk(tag, "ram_ce_n", ce, e.ce_n);
    if (e.bank_care) chk(tag, "ram_bank", bk, e.bank);
    chk(tag, "rom_off_n", ro, e.rom_off_n);
    chk(tag, "port_sel", pt, e.port);
    chk({tag, " R10"}, "ram_oe_n", oe, it.rd_n);
    chk({tag, " R10"}, "ram_we_n", we, it.wr_n);
    // Bus exclusivity: ROM driving and RAM driving never together.
    chk({tag, " R7 bus"}, "rom_and_ram_drive",
        (it.rom_int && ro) && (!ce && !oe), 1'b0);
  endtask

  // Monitor: pops each expected item and compares away from the clock edge.
  initial begin
    forever begin
      @(negedge clk);
      #3;
      while (exp_q.size() > 0) begin
        item_t it;
        string tg;
        it = exp_q.pop_front();
        tg = tag_q.pop_front();
        cmp_one({tg, " [a14=0]"}, it.e_a, it, a_ce_n, a_oe_n, a_we_n, a_bank, a_rom_off_n, a_port);
        cmp_one({tg, " [a14=1]"}, it.e_q, it, q_ce_n, q_oe_n, q_we_n, q_bank, q_rom_off_n, q_port);
      end
    end
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; shadow_sw = 1'b0;
    addr = 16'h0; mreq_n = 1'b1; iorq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; m1_n = 1'b1; rfsh_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    idle("R11 reset idle");
    bus(16'h0000, 0, 1, 0, 1, 1, 1, "R11 reset shadow off read");
    // R2 data map
    bus(16'h4000, 0, 1, 0, 1, 1, 1, "R2 read 4000");
    bus(16'h7FFF, 0, 1, 1, 0, 1, 1, "R2 write 7FFF");
    bus(16'hC000, 0, 1, 0, 1, 1, 1, "R2 read C000");
    bus(16'hFFFB, 0, 1, 1, 0, 1, 1, "R2 write FFFB");
    // R1 fetch fold
    bus(16'hC000, 0, 1, 0, 1, 0, 1, "R1 fetch C000");
    bus(16'hF00D, 0, 1, 0, 1, 0, 1, "R1 fetch F00D");
    bus(16'h4100, 0, 1, 0, 1, 0, 1, "R1 fetch 4100");
    // R6 port window
    bus(16'hFFFC, 0, 1, 0, 1, 1, 1, "R6 read FFFC");
    bus(16'hFFFF, 0, 1, 1, 0, 1, 1, "R6 write FFFF");
    bus(16'hFFFE, 0, 1, 0, 1, 0, 1, "R6 fetch FFFE folds");
    // R12 unmapped
    bus(16'h2000, 0, 1, 0, 1, 1, 1, "R12 read 2000");
    bus(16'h3FFF, 0, 1, 1, 0, 1, 1, "R12 write 3FFF");
    bus(16'h8000, 0, 1, 0, 1, 1, 1, "R12 read 8000");
    bus(16'hA000, 0, 1, 1, 0, 1, 1, "R12 write A000");
    // R4 ghost with shadow off
    bus(16'h0000, 0, 1, 1, 0, 1, 1, "R4 write 0000");
    bus(16'h1FFF, 0, 1, 1, 0, 1, 1, "R4 write 1FFF");
    bus(16'h1FFF, 0, 1, 0, 1, 1, 1, "R4 read 1FFF");
    bus(16'h8123, 0, 1, 0, 1, 0, 1, "R3 fetch 8123 shadow off");
    // R7 I/O and interrupt acknowledge
    bus(16'hFFFF, 1, 0, 0, 1, 1, 1, "R7 io read FFFF");
    bus(16'h0000, 1, 0, 1, 0, 1, 1, "R7 io write 0000");
    bus(16'h4000, 1, 0, 1, 1, 0, 1, "R7 intack 4000");
    bus(16'hC000, 0, 0, 0, 1, 1, 1, "R7 overlap C000");
    // R8 refresh
    bus(16'h1E40, 0, 1, 1, 1, 1, 0, "R8 refresh 1E40");
    bus(16'h4000, 0, 1, 1, 1, 1, 0, "R8 refresh 4000");
    bus(16'hC000, 0, 1, 1, 1, 1, 0, "R8 refresh C000");

    // R11 switch flips while /MREQ is held low: mode must not move.
    @(negedge clk) shadow_sw = 1'b1;
    for (int i = 0; i < 6; i++) bus(16'h0000, 0, 1, 0, 1, 1, 1, "R11 held mreq");
    for (int i = 0; i < 4; i++) idle("R11 idle load");
    exp_shadow = 1'b1;

    // R5 shadow on
    bus(16'h0000, 0, 1, 0, 1, 1, 1, "R5 read 0000");
    bus(16'h1ABC, 0, 1, 1, 0, 1, 1, "R5 write 1ABC");
    bus(16'h0100, 0, 1, 0, 1, 0, 1, "R5 fetch 0100");
    bus(16'h2000, 0, 1, 0, 1, 1, 1, "R12 read 2000 shadow on");
    // R3 variant difference
    bus(16'h8000, 0, 1, 0, 1, 0, 1, "R3 fetch 8000");
    bus(16'h9FFF, 0, 1, 0, 1, 0, 1, "R3 fetch 9FFF");
    bus(16'hC010, 0, 1, 0, 1, 0, 1, "R3 fetch C010");
    // R8 R9 with shadow on
    bus(16'h1E00, 0, 1, 1, 1, 1, 0, "R8 refresh 1E00 shadow on");
    bus(16'h0000, 1, 0, 0, 1, 1, 1, "R9 io 0000 shadow on");
    bus(16'h0000, 1, 1, 0, 1, 1, 1, "R9 idle rd 0000 shadow on");

    // R11 switch back off
    @(negedge clk) shadow_sw = 1'b0;
    for (int i = 0; i < 4; i++) idle("R11 idle unload");
    exp_shadow = 1'b0;
    bus(16'h0000, 0, 1, 0, 1, 1, 1, "R11 shadow off again read");
    bus(16'h0010, 0, 1, 1, 0, 1, 1, "R4 write 0010 after off");
    idle("final idle");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule